// File: doc/BRIEF.md
# SDRAM Command Timing Guard

The guard sits between an SDRAM command scheduler and the memory command pins. The scheduler presents one command request at a time. Each request carries a command code and a device select, and the system has two devices. The guard lets a request through only when every programmed minimum spacing since earlier commands to that device has run out. While any spacing is still running, the request waits with grant low, and the command outputs carry a no-operation code.

Each device has a 20-bit timing word made of five 4-bit fields. A field value v stands for a spacing of v+1 memory clock cycles. The fields set these spacings:

- precharge to any command;
- write to precharge;
- refresh to activate or refresh;
- the minimum time spent in self-refresh;
- self-refresh exit to activate.

The precharge and row-cycle spacings always come from device 0's word, for both devices. The write-recovery, self-refresh minimum and self-refresh exit spacings come from the word of the device being addressed.

There is one down-counter for each rule and each device. A counter is loaded with the raw field value when its triggering command issues, and it counts down to zero. Grant is combinational, so an allowed request issues in the same cycle it is presented.

Top module: `sdram_cmd_guard`

## Requirements
- R1: A field value v spaces the triggering command and the held command by v+1 cycles. If the trigger issues in cycle t, the held command can issue no earlier than cycle t+v+1. A value of 0 allows the very next cycle, and a value of 15 enforces 16 cycles.
- R2: After a precharge to a device, every command to that device waits for the precharge spacing. This spacing is read from bits [11:8] of device 0's word for both devices. Bits [11:8] of device 1's word have no effect.
- R3: After a write to a device, a precharge to that device waits for the write-recovery spacing. This spacing is taken from bits [3:0] of that device's own word. Reads are not held by it.
- R4: After a refresh to a device, both activate and refresh to that device wait for the row-cycle spacing. This spacing is read from bits [7:4] of device 0's word for both devices.
- R5: After self-refresh entry, exit to that device waits for the minimum self-refresh spacing in bits [19:16] of the device's word. While a device is in self-refresh, every other command to it is held. An exit request to a device that is not in self-refresh is held.
- R6: After self-refresh exit, an activate to that device waits for the exit spacing in bits [15:12] of the device's word.
- R7: Command codes are 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 self-refresh entry and 7 self-refresh exit. An allowed request is granted in the same cycle, with the command and device driven on the issue outputs. A held request keeps grant low and drives code 0 and device 0 on the outputs.
- R8: Spacings are tracked per device, so a command to one device never holds a command to the other.
- R9: Synchronous reset clears every counter and the self-refresh state, so the first request after reset is granted at once.
- R10: A change to a timing field affects only counters loaded after the change. A spacing already running completes with the value it was loaded with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Requested command code |
| req_dev | input | 1 | Target device |
| tim_cfg | input | 40 | Timing words; device 0 in [19:0], device 1 in [39:20] |
| grant | output | 1 | The request issues in this cycle |
| iss_cmd | output | 3 | Issued command code, 0 when idle |
| iss_dev | output | 1 | Issued device, 0 when idle |

## Verification
The bench builds the guard with its default 4-bit fields and two devices. With these values, the largest spacing of 16 cycles and the smallest of 1 cycle can both be reached directly. Having two devices lets the bench put different values into device 1's precharge and row-cycle fields and show they are ignored. It also shows that device 1's write recovery is used for device 1, and that a long spacing on one device leaves the other free.

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard #(
  parameter int FW = 4,
  parameter int NDEV = 2,
  localparam int DW = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int TW = 5 * FW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [DW-1:0]     req_dev,
  input  logic [NDEV*TW-1:0] tim_cfg,
  output logic              grant,
  output logic [2:0]        iss_cmd,
  output logic [DW-1:0]     iss_dev
);
  localparam int WR_LO = 0;
  localparam int RC_LO = FW;
  localparam int RP_LO = 2 * FW;
  localparam int XS_LO = 3 * FW;
  localparam int SR_LO = 4 * FW;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_SRE = 3'd6, C_SRX = 3'd7;

  wire [FW-1:0] rp_f = tim_cfg[RP_LO +: FW];
  wire [FW-1:0] rc_f = tim_cfg[RC_LO +: FW];

  logic [NDEV-1:0] sel, ok;

  assign grant   = req_valid && (req_cmd != C_NOP) && |(ok & sel);
  assign iss_cmd = grant ? req_cmd : C_NOP;
  assign iss_dev = grant ? req_dev : '0;

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    wire [TW-1:0] w = tim_cfg[d*TW +: TW];
    logic [FW-1:0] rp_c, wr_c, rc_c, sr_c, xs_c;
    logic in_sr;
    wire hit = grant && sel[d];

    assign sel[d] = (req_dev == DW'(d));

    always_comb begin
      case (req_cmd)
        C_ACT:        ok[d] = !in_sr && rp_c == 0 && rc_c == 0 && xs_c == 0;
        C_RD, C_WR:   ok[d] = !in_sr && rp_c == 0;
        C_PRE:        ok[d] = !in_sr && rp_c == 0 && wr_c == 0;
        C_REF:        ok[d] = !in_sr && rp_c == 0 && rc_c == 0;
        C_SRE:        ok[d] = !in_sr && rp_c == 0;
        C_SRX:        ok[d] = in_sr && sr_c == 0;
        default:      ok[d] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rp_c <= '0; wr_c <= '0; rc_c <= '0; sr_c <= '0; xs_c <= '0;
        in_sr <= 1'b0;
      end else begin
        if (hit && req_cmd == C_PRE) rp_c <= rp_f;
        else if (rp_c != 0) rp_c <= rp_c - 1'b1;
        if (hit && req_cmd == C_WR) wr_c <= w[WR_LO +: FW];
        else if (wr_c != 0) wr_c <= wr_c - 1'b1;
        if (hit && req_cmd == C_REF) rc_c <= rc_f;
        else if (rc_c != 0) rc_c <= rc_c - 1'b1;
        if (hit && req_cmd == C_SRE) sr_c <= w[SR_LO +: FW];
        else if (sr_c != 0) sr_c <= sr_c - 1'b1;
        if (hit && req_cmd == C_SRX) xs_c <= w[XS_LO +: FW];
        else if (xs_c != 0) xs_c <= xs_c - 1'b1;
        if (hit && req_cmd == C_SRE) in_sr <= 1'b1;
        else if (hit && req_cmd == C_SRX) in_sr <= 1'b0;
      end
    end

    a_r2_pre_hold: assert property (@(posedge clk) disable iff (rst)
      (grant && iss_cmd == C_PRE && iss_dev == DW'(d) && rp_f != 0)
      |=> !(grant && iss_dev == DW'(d)));

    a_r3_wr_recovery: assert property (@(posedge clk) disable iff (rst)
      (grant && iss_cmd == C_WR && iss_dev == DW'(d) && w[WR_LO +: FW] != 0)
      |=> !(grant && iss_cmd == C_PRE && iss_dev == DW'(d)));

    a_r4_row_cycle: assert property (@(posedge clk) disable iff (rst)
      (grant && iss_cmd == C_REF && iss_dev == DW'(d) && rc_f != 0)
      |=> !(grant && iss_dev == DW'(d) && (iss_cmd == C_ACT || iss_cmd == C_REF)));

    a_r5_sr_minimum: assert property (@(posedge clk) disable iff (rst)
      (grant && iss_cmd == C_SRE && iss_dev == DW'(d) && w[SR_LO +: FW] != 0)
      |=> !(grant && iss_cmd == C_SRX && iss_dev == DW'(d)));

    a_r5_sr_only_exit: assert property (@(posedge clk) disable iff (rst)
      (in_sr && grant && iss_dev == DW'(d)) |-> iss_cmd == C_SRX);

    a_r6_exit_to_act: assert property (@(posedge clk) disable iff (rst)
      (grant && iss_cmd == C_SRX && iss_dev == DW'(d) && w[XS_LO +: FW] != 0)
      |=> !(grant && iss_cmd == C_ACT && iss_dev == DW'(d)));
  end

  a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    grant |-> (req_valid && req_cmd != C_NOP));
endmodule

// File: tb/sim_sdram_cmd_guard.sv
module sim_sdram_cmd_guard;
  logic clk = 0, rst = 1, req_valid = 0, req_dev = 0;
  logic [2:0] req_cmd = 0;
  logic [19:0] tim0, tim1;
  logic grant, iss_dev;
  logic [2:0] iss_cmd;
  int checks = 0, fails = 0;
  bit done = 0;

  sdram_cmd_guard u0 (.clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_dev(req_dev), .tim_cfg({tim1, tim0}), .grant(grant), .iss_cmd(iss_cmd), .iss_dev(iss_dev));

  always #4 clk = ~clk;

  function automatic logic [19:0] mk(int sr, int xs, int rp, int rc, int wr);
    return {sr[3:0], xs[3:0], rp[3:0], rc[3:0], wr[3:0]};
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic d, output int w);
    w = 0;
    @(negedge clk); req_valid = 1; req_cmd = c; req_dev = d;
    #1;
    while (!grant && w < 100) begin @(negedge clk); #1; w++; end
    if (grant) begin
      chk(iss_cmd, c, "R7 issued code");
      chk(iss_dev, d, "R7 issued device");
    end
    @(posedge clk); #1; req_valid = 0; req_cmd = 0; req_dev = 0;
  endtask

  task automatic pair(logic [2:0] a, logic da, logic [2:0] b, logic db, int exp, string tag);
    int w;
    issue(a, da, w);
    issue(b, db, w);
    chk(w, exp, tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hold_check(logic [2:0] c, logic d, int n, string tag);
    int g = 0, bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); req_valid = 1; req_cmd = c; req_dev = d;
      #1;
      if (grant) g++;
      if (iss_cmd != 0 || iss_dev != 0) bad++;
    end
    @(posedge clk); #1; req_valid = 0; req_cmd = 0; req_dev = 0;
    chk(g, 0, tag);
    chk(bad, 0, "R7 idle outputs are NOP");
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk(grant, 0, "R9 grant low in reset");
    chk(iss_cmd, 0, "R9 NOP in reset");
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    int w;
    do_reset();
    issue(3'd1, 0, w);
    chk(w, 0, "R9 first command immediate");
    idle(20);
    tim0 = mk(6, 3, 9, 4, 3);
    issue(3'd4, 0, w);
    do_reset();
    issue(3'd1, 0, w);
    chk(w, 0, "R9 reset clears precharge count");
    issue(3'd6, 1, w);
    do_reset();
    issue(3'd2, 1, w);
    chk(w, 0, "R9 reset leaves self-refresh");
    tim0 = mk(6, 3, 5, 4, 3);
    idle(20);
  endtask

  task automatic t_precharge();
    pair(3'd4, 0, 3'd1, 0, 5, "R2 precharge spacing dev0");
    idle(20);
    pair(3'd4, 1, 3'd1, 1, 5, "R2 dev1 uses dev0 field");
    idle(20);
    tim0 = mk(6, 3, 0, 4, 3);
    pair(3'd4, 0, 3'd2, 0, 0, "R1 field 0 means one cycle");
    idle(20);
    tim0 = mk(6, 3, 15, 4, 3);
    pair(3'd4, 0, 3'd3, 0, 15, "R1 field 15 means sixteen cycles");
    tim0 = mk(6, 3, 5, 4, 3);
    idle(20);
  endtask

  task automatic t_write();
    pair(3'd3, 0, 3'd4, 0, 3, "R3 write recovery dev0");
    idle(20);
    pair(3'd3, 1, 3'd4, 1, 7, "R3 write recovery dev1 own field");
    idle(20);
    pair(3'd3, 0, 3'd2, 0, 0, "R3 read not held by write");
    idle(20);
  endtask

  task automatic t_refresh();
    pair(3'd5, 0, 3'd5, 0, 4, "R4 refresh to refresh");
    idle(20);
    pair(3'd5, 0, 3'd1, 0, 4, "R4 refresh to activate");
    idle(20);
    pair(3'd5, 1, 3'd5, 1, 4, "R4 dev1 uses dev0 row cycle");
    idle(20);
  endtask

  task automatic t_selfref();
    int w;
    pair(3'd6, 0, 3'd7, 0, 6, "R5 minimum self-refresh");
    issue(3'd1, 0, w);
    chk(w, 3, "R6 exit to activate");
    idle(20);
    issue(3'd6, 0, w);
    hold_check(3'd1, 0, 6, "R5 activate held in self-refresh");
    idle(10);
    issue(3'd7, 0, w);
    chk(w, 0, "R5 exit after minimum elapsed");
    idle(20);
    hold_check(3'd7, 0, 4, "R5 exit held outside self-refresh");
    idle(20);
    pair(3'd6, 1, 3'd7, 1, 2, "R5 dev1 own minimum");
    issue(3'd1, 1, w);
    chk(w, 1, "R6 dev1 own exit spacing");
    idle(20);
  endtask

  task automatic t_devices();
    tim0 = mk(6, 3, 10, 4, 3);
    pair(3'd4, 0, 3'd1, 1, 0, "R8 dev1 free during dev0 precharge");
    idle(20);
    pair(3'd5, 1, 3'd5, 0, 0, "R8 dev0 free after dev1 refresh");
    tim0 = mk(6, 3, 5, 4, 3);
    idle(20);
  endtask

  task automatic t_change();
    int w;
    tim0 = mk(6, 3, 8, 4, 3);
    issue(3'd4, 0, w);
    tim0 = mk(6, 3, 1, 4, 3);
    issue(3'd1, 0, w);
    chk(w, 8, "R10 running count keeps old value");
    idle(20);
    pair(3'd4, 0, 3'd1, 0, 1, "R10 new value on next load");
    tim0 = mk(6, 3, 5, 4, 3);
    idle(20);
  endtask

  initial begin
    tim0 = mk(6, 3, 5, 4, 3);
    tim1 = mk(2, 1, 2, 11, 7);
    idle(3);
    t_reset();
    t_precharge();
    t_write();
    t_refresh();
    t_selfref();
    t_devices();
    t_change();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule